// File: doc/BRIEF.md
# PCI Memory-Read Target

This block answers memory reads on a 32-bit PCI bus. It watches for the start of a new transaction. On the first clock edge where the cycle-active line is seen asserted after an idle bus, it checks two things: the bus command must be a memory read, and the address must fall inside a window. The window has a base address and a size of a power of two, both set by parameters. If both hold, the block claims the cycle. It then keeps its ready line low for one turnaround clock, so that the master can release the shared address/data lines. After that it returns one 32-bit word per data phase. The words come from a local read port.

The local side sees the current word address. It supplies a data word together with a valid flag. The target raises its ready line only while that flag is high, so a slow local source appears on the bus as target wait cycles. A word moves on a clock edge only when both the master ready and the target ready are high. The block then pulses a take strobe to the local side and advances the address by one word. A burst ends with the transfer that happens while the cycle-active line is already low. At that point the target lets go of the bus. It will not answer again until the bus has been fully idle for one clock.

The shared address/data bus is split into an input, an output and an output enable. All bus control signals here are active high.

Top module: `pci_rd_target`

## Requirements
- R1: While reset is asserted, and after it, the claim, target-ready and data-output-enable outputs are low.
- R2: A cycle is claimed only when the command nibble equals 0110 on the address edge. Any other command leaves all target outputs low for the whole transaction.
- R3: After a claiming address edge, claim is high in the next cycle (the turnaround), while target-ready and output-enable stay low.
- R4: The data-output-enable is high only while claim is high, and it is high in every cycle from the first data cycle to the last.
- R5: In a data cycle, target-ready equals the local valid flag. When target-ready is high, the data output carries the local word for the current address.
- R6: A word moves only on an edge where master-ready and target-ready are both high. The take strobe is high exactly in those cycles, and in any other cycle the address is held.
- R7: The word address starts at the captured address with bits [1:0] cleared. It increases by 4 after each word moved.
- R8: The cycle after the transfer made with cycle-active low, claim, target-ready and output-enable are all low.
- R9: An address edge counts only if, on the edge before it, both cycle-active and master-ready were low.
- R10: An address hits when its bits above WIN_BITS equal those of BASE_ADDR. The last word of the window is claimed, and the first address past the window is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_active_i | input | 1 | Master holds a transaction open |
| mst_ready_i | input | 1 | Master ready for the current data phase |
| ad_i | input | 32 | Address/data bus, input side |
| cmd_be_i | input | 4 | Command on the address edge, byte lanes afterwards |
| ad_o | output | 32 | Address/data bus, output side |
| ad_oe_o | output | 1 | Output enable for ad_o |
| claim_o | output | 1 | Target has claimed the cycle |
| tgt_ready_o | output | 1 | Target ready for the current data phase |
| lrd_addr_o | output | 32 | Local read word address |
| lrd_take_o | output | 1 | Local word consumed this cycle |
| lrd_valid_i | input | 1 | Local word is available |
| lrd_data_i | input | 32 | Local word for lrd_addr_o |

## Verification
The bench runs three kinds of bursts: ones where the master inserts waits, ones where the local source stalls, and ones where both happen. A target that counted a beat while master-ready was low would move its address too early, and the next word it returned would be wrong. A target that drove data in the turnaround cycle would show ready or output-enable one clock early. The bench also tests the two window edges, wrong commands, and an address edge that follows a non-idle bus. A loose decoder would claim in those cases, and a target that did not wait for an idle bus would claim the tail of another transaction.

// File: rtl/pci_rd_target.sv
module pci_rd_target #(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          WIN_BITS  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_active_i,
  input  logic        mst_ready_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cmd_be_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic        claim_o,
  output logic        tgt_ready_o,
  output logic [31:0] lrd_addr_o,
  output logic        lrd_take_o,
  input  logic        lrd_valid_i,
  input  logic [31:0] lrd_data_i
);
  localparam logic [31:0] WIN_MASK   = ~((32'd1 << WIN_BITS) - 32'd1);
  localparam logic [3:0]  CMD_MEM_RD = 4'b0110;

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_DATA} st_t;

  st_t  st;
  logic bus_idle_q;
  logic hit;
  logic xfer;

  assign hit = (st == S_IDLE) && bus_idle_q && cyc_active_i &&
               (cmd_be_i == CMD_MEM_RD) &&
               ((ad_i & WIN_MASK) == (BASE_ADDR & WIN_MASK));

  assign claim_o     = (st != S_IDLE);
  assign ad_oe_o     = (st == S_DATA);
  assign tgt_ready_o = ad_oe_o && lrd_valid_i;
  assign ad_o        = lrd_data_i;
  assign xfer        = tgt_ready_o && mst_ready_i;
  assign lrd_take_o  = xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bus_idle_q <= 1'b0;
      lrd_addr_o <= '0;
    end else begin
      bus_idle_q <= !cyc_active_i && !mst_ready_i;
      case (st)
        S_IDLE: if (hit) begin
          st         <= S_TURN;
          lrd_addr_o <= {ad_i[31:2], 2'b00};
        end
        S_TURN: st <= S_DATA;
        S_DATA: if (xfer) begin
          lrd_addr_o <= lrd_addr_o + 32'd4;
          if (!cyc_active_i) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pci_rd_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_active_i,
  input logic        mst_ready_i,
  input logic [3:0]  cmd_be_i,
  input logic        ad_oe_o,
  input logic        claim_o,
  input logic        tgt_ready_o,
  input logic [31:0] lrd_addr_o,
  input logic        lrd_take_o,
  input logic        lrd_valid_i
);
  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim_o) |-> !tgt_ready_o && !ad_oe_o); // R3
  AST_CLAIM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim_o) |-> $past(cmd_be_i) == 4'b0110 && $past(cyc_active_i)); // R2
  AST_OE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> claim_o); // R4
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_ready_o |-> lrd_valid_i); // R5
  AST_TAKE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lrd_take_o |-> tgt_ready_o && mst_ready_i); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o && !lrd_take_o) |=> lrd_addr_o == $past(lrd_addr_o)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lrd_take_o |=> lrd_addr_o == $past(lrd_addr_o) + 32'd4); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (lrd_take_o && !cyc_active_i) |=> !claim_o && !ad_oe_o && !tgt_ready_o); // R8
endmodule

bind pci_rd_target pci_rd_target_chk u_chk (.*);

// File: tb/pci_rd_target_tb.sv
module pci_rd_target_tb;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] DKEY = 32'hC3A5_0F00;
  localparam int NVEC = 10;
  // fields: cmd[72:69] addr[68:37] beats[36:33] mst_ready pattern[32:17] local valid pattern[16:1] claim[0]
  localparam logic [72:0] VEC [NVEC] = '{
    {4'h6, BASE,              4'd1, 16'hFFFF, 16'hFFFF, 1'b1},
    {4'h6, BASE + 32'h100,    4'd4, 16'hFFFF, 16'hFFFF, 1'b1},
    {4'h6, BASE + 32'h20,     4'd3, 16'hAAAA, 16'hFFFF, 1'b1},
    {4'h6, BASE + 32'h40,     4'd4, 16'hFFFF, 16'hCC33, 1'b1},
    {4'h6, BASE + 32'hFFC,    4'd1, 16'hFFFF, 16'hFFFF, 1'b1},  // R10 last word
    {4'h6, BASE + 32'h1000,   4'd1, 16'hFFFF, 16'hFFFF, 1'b0},  // R10 past window
    {4'h7, BASE,              4'd1, 16'hFFFF, 16'hFFFF, 1'b0},  // R2
    {4'h2, BASE,              4'd1, 16'hFFFF, 16'hFFFF, 1'b0},  // R2
    {4'h6, BASE - 32'h4,      4'd1, 16'hFFFF, 16'hFFFF, 1'b0},  // R10 below base
    {4'h6, BASE + 32'h32,     4'd2, 16'h5555, 16'h9696, 1'b1}   // R7 unaligned start
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_active_i = 1'b0, mst_ready_i = 1'b0, lrd_valid_i = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cmd_be_i = '0;
  logic [31:0] ad_o, lrd_addr_o, lrd_data_i;
  logic ad_oe_o, claim_o, tgt_ready_o, lrd_take_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always_comb lrd_data_i = lrd_addr_o ^ DKEY;

  pci_rd_target u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk({claim_o, ad_oe_o, tgt_ready_o} == 3'b000, tag, {claim_o, ad_oe_o, tgt_ready_o}, 0);
  endtask

  task automatic run_txn(input logic [72:0] v);
    logic [3:0] cmd = v[72:69];
    logic [31:0] addr = v[68:37];
    int beats = int'(v[36:33]);
    logic [15:0] iw = v[32:17], vw = v[16:1];
    bit claim = v[0];
    logic [31:0] wa = {addr[31:2], 2'b00};
    int k = 0;
    bit hold = 0;
    @(negedge clk);
    cyc_active_i = 1; mst_ready_i = 0; ad_i = addr; cmd_be_i = cmd; lrd_valid_i = 0;
    @(negedge clk);
    ad_i = '0; cmd_be_i = 4'h0;
    for (int c = 0; c < 64 && (claim ? k < beats : c < 4); c++) begin
      bit ir, et;
      if (c > 0) @(negedge clk);
      ir = hold | iw[c % 16];
      mst_ready_i = ir;
      if (ir && k == beats - 1) cyc_active_i = 0;
      lrd_valid_i = vw[c % 16];
      #2;
      et = claim && c > 0 && lrd_valid_i;
      chk(claim_o == claim, claim ? "R3" : "R2", claim_o, claim);
      chk(ad_oe_o == (claim && c > 0), c == 0 ? "R3" : "R4", ad_oe_o, claim && c > 0);
      chk(tgt_ready_o == et, "R5", tgt_ready_o, et);
      chk(lrd_take_o == (ir && et), "R6", lrd_take_o, ir && et);
      if (claim && c > 0) chk(lrd_addr_o == wa + 32'(4 * k), "R7", lrd_addr_o, wa + 32'(4 * k));
      if (et) chk(ad_o == ((wa + 32'(4 * k)) ^ DKEY), "R5", ad_o, (wa + 32'(4 * k)) ^ DKEY);
      if (ir && et) begin k++; hold = 0; end else hold = ir;
    end
    if (claim) chk(k == beats, "R6", k, beats);
    @(negedge clk);
    cyc_active_i = 0; mst_ready_i = 0; lrd_valid_i = 0;
    #2 quiet("R8");
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #5 quiet("R1");
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #2 quiet("R1");
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) run_txn(VEC[i]);

    // R9: address edge right after a busy edge must not claim
    @(negedge clk);
    cyc_active_i = 0; mst_ready_i = 1;
    @(negedge clk);
    cyc_active_i = 1; mst_ready_i = 0; ad_i = BASE; cmd_be_i = 4'h6;
    @(negedge clk);
    #2 chk(claim_o == 1'b0, "R9", claim_o, 0);
    cyc_active_i = 0; ad_i = '0; cmd_be_i = '0;
    @(negedge clk);
    run_txn({4'h6, BASE + 32'h8, 4'd2, 16'hFFFF, 16'hFFFF, 1'b1});

    // R1: reset in the middle of a data phase
    @(negedge clk);
    cyc_active_i = 1; ad_i = BASE; cmd_be_i = 4'h6;
    @(negedge clk);
    ad_i = '0; mst_ready_i = 1;
    @(negedge clk);
    lrd_valid_i = 1;
    #2 chk(tgt_ready_o == 1'b1, "R5", tgt_ready_o, 1);
    rst_n = 0;
    #2 quiet("R1");
    cyc_active_i = 0; mst_ready_i = 0; lrd_valid_i = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2 quiet("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule